// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one burst for an SDRAM-style memory model or controller. A start strobe captures a starting column together with a burst-length code and an ordering bit. From the next cycle the block presents one column address per clock, with a valid flag, until the burst runs out or is cut short. A done flag marks the last address of a fixed-length burst.

The sequential ordering counts the low bits upward and wraps inside the aligned block that the burst length defines. The interleaved ordering XORs the starting low bits with a running index. A full-page sequential burst walks the whole 512-column row, wraps from the top column to zero and only ends on a stop. A new start may arrive on any cycle, including in the middle of a burst, and it restarts generation from its own column. A stop ends the burst on the next edge.

Top module: `col_burst_gen`

## Requirements
- R1: While reset is high and in the first cycle after it falls, valid_o and done_o are 0 and col_o is 0.
- R2: When start_i is high at a clock edge, col_o equals the sampled col_i and valid_o is 1 in the cycle after that edge.
- R3: Length code len_i selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The reserved codes 4, 5 and 6 give 8.
- R4: With order_i = 0 (sequential), the k-th address (k counted from 0) keeps every column bit above log2(BL) of the start column. Its low log2(BL) bits equal (start + k) mod BL.
- R5: With order_i = 1 (interleaved), the k-th address keeps the upper bits of the start column. Its low log2(BL) bits equal the starting low bits XOR k.
- R6: A full-page sequential burst steps by +1 modulo 512, so column 511 is followed by 0. It keeps valid_o high without ever raising done_o until a stop or a new start arrives.
- R7: Interleaved ordering with length code 7 runs as a burst of 8.
- R8: For a fixed-length burst, done_o is high exactly in the cycle that shows the last address. Without a new start, valid_o is 0 in the following cycle.
- R9: stop_i high at an edge without start_i makes valid_o 0 in the next cycle. A stop while idle leaves valid_o at 0.
- R10: A start during a running burst, including in its last cycle, restarts it with the new column, length and ordering.
- R11: When start_i and stop_i are high at the same edge, the start wins and a new burst begins.
- R12: done_o is never high while valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst, or restart the running one |
| col_i | input | 9 | Starting column sampled with start_i |
| len_i | input | 3 | Burst-length code sampled with start_i |
| order_i | input | 1 | Ordering sampled with start_i: 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the running burst |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | col_o holds an address of a live burst |
| done_o | output | 1 | col_o is the last address of a fixed-length burst |

## Verification
Two functions can coincide in one cycle: a stop and a start can land on the same edge, and a new start can land on the final address of a burst, where the natural end would otherwise drop valid_o. The bench provokes both directly. In the first case it expects the new burst's first column one cycle later. In the second it expects valid_o to stay high with the new column, while done_o is still seen high on the old burst's last address in the cycle before. Each cycle's expected valid, done and column come from a model of the requirements, queued by the driver and compared by the monitor.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W   = 9;
    localparam int CODE_W  = 3;
    localparam int ROW_COLS = 1 << COL_W;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        col_t   mask;     // BL-1: the bits that move during the burst
        logic   full;     // full-page burst, ends only on stop
        order_e order;
    } burst_cfg_t;

    typedef struct packed {
        logic active;
        col_t base;
        col_t idx;
    } burst_state_t;

    // Length code to block mask; full page only with sequential order.
    function automatic burst_cfg_t decode_cfg(logic [CODE_W-1:0] code, logic ord);
        burst_cfg_t c;
        c.order = order_e'(ord);
        c.full  = 1'b0;
        case (code)
            3'd0: c.mask = col_t'(0);
            3'd1: c.mask = col_t'(1);
            3'd2: c.mask = col_t'(3);
            3'd3: c.mask = col_t'(7);
            3'd7: begin
                if (ord == 1'b0) begin
                    c.mask = col_t'(ROW_COLS - 1);
                    c.full = 1'b1;
                end else begin
                    c.mask = col_t'(7);
                end
            end
            default: c.mask = col_t'(7);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              order_i,
    output burst_cfg_t        cfg_o
);
    always_comb begin
        cfg_o = decode_cfg(code_i, order_i);
    end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] mask_i,
    input  order_e       order_i,
    output logic [W-1:0] col_o
);
    logic [W-1:0] seq_low;
    logic [W-1:0] ilv_low;

    assign seq_low = base_i + idx_i;
    assign ilv_low = base_i ^ idx_i;

    // Per column bit: fixed bits come from the base, moving bits from the order.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (!mask_i[b])
                col_o[b] = base_i[b];
            else if (order_i == ORD_INTLV)
                col_o[b] = ilv_low[b];
            else
                col_o[b] = seq_low[b];
        end
    end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stop_i,
    input  col_t         col_i,
    input  burst_cfg_t   cfg_i,
    output burst_state_t st_o,
    output burst_cfg_t   cfg_o,
    output logic         last_o
);
    burst_state_t st_q, st_d;
    burst_cfg_t   cfg_q, cfg_d;

    assign last_o = st_q.active && !cfg_q.full && (st_q.idx == cfg_q.mask);

    always_comb begin
        st_d  = st_q;
        cfg_d = cfg_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = col_i;
            st_d.idx    = '0;
            cfg_d       = cfg_i;
        end else if (stop_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (last_o)
                st_d.active = 1'b0;
            else
                st_d.idx = st_q.idx + col_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cfg_q <= '0;
        end else begin
            st_q  <= st_d;
            cfg_q <= cfg_d;
        end
    end

    assign st_o  = st_q;
    assign cfg_o = cfg_q;
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [CODE_W-1:0] len_i,
    input  logic              order_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              done_o
);
    burst_cfg_t   new_cfg;
    burst_cfg_t   cfg_q;
    burst_state_t st_q;
    logic         last_w;
    logic [COL_W-1:0] cfg_mask;
    logic         cfg_full;

    burst_len_decode u_dec (
        .code_i  (len_i),
        .order_i (order_i),
        .cfg_o   (new_cfg)
    );

    burst_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .stop_i  (stop_i),
        .col_i   (col_i),
        .cfg_i   (new_cfg),
        .st_o    (st_q),
        .cfg_o   (cfg_q),
        .last_o  (last_w)
    );

    burst_addr_map #(.W(COL_W)) u_map (
        .base_i  (st_q.base),
        .idx_i   (st_q.idx),
        .mask_i  (cfg_q.mask),
        .order_i (cfg_q.order),
        .col_o   (col_o)
    );

    assign valid_o  = st_q.active;
    assign done_o   = last_w;
    assign cfg_mask = cfg_q.mask;
    assign cfg_full = cfg_q.full;
endmodule

// File: rtl/burst_gen_chk.sv
module burst_gen_chk
    import burst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             done_o,
    input logic [COL_W-1:0] blk_mask,
    input logic             full_page
);
    p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(col_i)));

    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !start_i && !stop_i && !done_o)
        |=> (((col_o ^ $past(col_o)) & ~$past(blk_mask)) == '0));

    p_fullpage_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && full_page && !start_i && !stop_i)
        |=> (valid_o && !done_o && col_o == $past(col_o) + 9'd1));

    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !valid_o);

    p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !valid_o);

    p_start_beats_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (start_i && stop_i) |=> valid_o);

    p_done_needs_valid_r12: assert property (@(posedge clk) disable iff (rst)
        done_o |-> valid_o);
endmodule

bind col_burst_gen burst_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .col_i     (col_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .done_o    (done_o),
    .blk_mask  (cfg_mask),
    .full_page (cfg_full)
);

// File: tb/tb_col_burst_gen.sv
module tb_col_burst_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [8:0] col_i = '0;
    logic [2:0] len_i = '0;
    logic       order_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       done_o;

    col_burst_gen dut (
        .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i), .len_i(len_i),
        .order_i(order_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o),
        .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic       valid;
        logic       done;
        logic [8:0] col;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench model state, built from the requirements
    bit         m_act = 0;
    logic [8:0] m_base = '0;
    int         m_idx = 0;
    int         m_len = 1;
    bit         m_full = 0;
    bit         m_ilv = 0;

    function automatic int len_of(logic [2:0] code, logic ord);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd7: return ord ? 8 : 512;
            default: return 8;
        endcase
    endfunction

    function automatic logic [8:0] model_col();
        logic [8:0] msk;
        logic [8:0] k;
        msk = 9'(m_len - 1);
        k   = 9'(m_idx);
        if (m_ilv) return (m_base & ~msk) | ((m_base ^ k) & msk);
        return (m_base & ~msk) | ((m_base + k) & msk);
    endfunction

    // Drive one cycle and queue what must be seen after the next edge.
    task automatic step(input bit st, input logic [8:0] c, input logic [2:0] code,
                        input bit ord, input bit sp, input string req);
        exp_t e;
        @(negedge clk);
        start_i = st; col_i = c; len_i = code; order_i = ord; stop_i = sp;
        if (st) begin
            m_act = 1; m_base = c; m_idx = 0;
            m_len = len_of(code, ord); m_full = (code == 3'd7) && !ord; m_ilv = ord;
        end else if (sp) begin
            m_act = 0;
        end else if (m_act) begin
            if (!m_full && m_idx == m_len - 1) m_act = 0;
            else m_idx = (m_idx + 1) % 512;
        end
        e.valid = m_act;
        e.done  = m_act && !m_full && (m_idx == m_len - 1);
        e.col   = model_col();
        e.req   = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, '0, 3'd0, 0, 0, req);
    endtask

    // Monitor: one comparison per cycle, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (valid_o !== e.valid || done_o !== e.done ||
                    (e.valid && col_o !== e.col)) begin
                    failures++;
                    $display("FAIL %s: valid=%0b done=%0b col=%0d expected valid=%0b done=%0b col=%0d",
                             e.req, valid_o, done_o, col_o, e.valid, e.done, e.col);
                end
                checks++;
                if (done_o && !valid_o) begin
                    failures++;
                    $display("FAIL R12: done=1 valid=0 expected done=0");
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, expected end before %0d cycles", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        checks++;
        if (valid_o !== 1'b0 || done_o !== 1'b0 || col_o !== 9'd0) begin
            failures++;
            $display("FAIL R1: valid=%0b done=%0b col=%0d expected 0 0 0", valid_o, done_o, col_o);
        end
        @(negedge clk);
        rst = 1'b0;
        idle(1, "R1");

        // R3/R4/R8: sequential length 4 from 5 -> 5,6,7,4
        step(1, 9'd5, 3'd2, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R4"); step(0, 0, 0, 0, 0, "R4"); step(0, 0, 0, 0, 0, "R8");
        idle(2, "R8");
        // R3: length 1 at top column
        step(1, 9'h1FF, 3'd0, 0, 0, "R3");
        idle(2, "R8");
        // R3/R4: length 2 and length 8
        step(1, 9'h0FB, 3'd1, 0, 0, "R3");
        idle(2, "R4");
        step(1, 9'h0FE, 3'd3, 0, 0, "R3");
        idle(9, "R4");
        // R5: interleaved length 8 from 5 -> 5,4,7,6,1,0,3,2 and length 4
        step(1, 9'd5, 3'd3, 1, 0, "R5");
        idle(8, "R5");
        step(1, 9'h1A3, 3'd2, 1, 0, "R5");
        idle(5, "R5");
        // R7: interleave with full-page code runs as 8
        step(1, 9'h012, 3'd7, 1, 0, "R7");
        idle(9, "R7");
        // R3: reserved code 5 runs as 8
        step(1, 9'h033, 3'd5, 0, 0, "R3");
        idle(9, "R3");
        // R6/R9: full page wraps 511 -> 0, then stop
        step(1, 9'h1FC, 3'd7, 0, 0, "R6");
        idle(10, "R6");
        step(0, 0, 0, 0, 1, "R9");
        idle(2, "R9");
        // R9: stop while idle has no effect
        step(0, 0, 0, 0, 1, "R9");
        idle(1, "R9");
        // R10: restart mid burst with new settings
        step(1, 9'd16, 3'd3, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10"); step(0, 0, 0, 0, 0, "R10");
        step(1, 9'd42, 3'd2, 1, 0, "R10");
        idle(5, "R10");
        // R11: start and stop in one cycle
        step(1, 9'd100, 3'd3, 0, 0, "R11");
        step(0, 0, 0, 0, 0, "R11");
        step(1, 9'd200, 3'd1, 0, 1, "R11");
        idle(3, "R11");
        // R10: start on last address of a burst keeps valid high
        step(1, 9'd8, 3'd1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R8");
        step(1, 9'd300, 3'd2, 1, 0, "R10");
        idle(5, "R10");
        // R11: start and stop together from idle
        step(1, 9'd77, 3'd0, 0, 1, "R11");
        idle(3, "R11");

        @(negedge clk);
        start_i = 0; stop_i = 0;
        wait (exp_q.size() == 0);
        @(posedge clk);
        #(CLK_PERIOD/2);
        finish_run();
    end
endmodule